// File: doc/BRIEF.md
# Manchester Word Decoder with Sync Recognition

This block receives serial words coded in Manchester II and recovers their contents. It runs from a decoder clock at a fixed oversampling ratio, 12 samples per bit time by default. The line can come from one of two sources, chosen by a select input. The first source is a pair of complementary inputs, one for the positive bus level and one for the negative bus level. The second source is a single input that already carries the logic level. The chosen level passes through synchronizer flops before it reaches the decoder.

Each word has 20 bit times. It opens with a sync that is 3 bit times long: one level for a bit time and a half, then the opposite level for a bit time and a half. Sixteen data bits follow, and one parity bit closes the word. The sync starts high for a command word and low for a data word. The decoder recognizes the sync and reports its type. It takes its bit timing from the transition in the middle of the sync. It then sends each data bit out, most significant bit first, with a one-cycle shift strobe. It checks odd parity over the 16 data bits and the parity bit. When the whole word is clean, it raises a valid flag for one bit time.

The controller has three states. ST_HUNT searches for a sync. ST_SYNC2 watches the second half of the sync. ST_DATA samples the bits. The transitions between them are:
- ST_HUNT to ST_SYNC2: a line edge ends a run of a bit time and a half, within one sample.
- ST_SYNC2 to ST_HUNT: an edge comes too early.
- ST_SYNC2 to ST_DATA: the second level has been held long enough.
- ST_DATA to ST_HUNT: a Manchester error occurs, or the parity bit has been processed.
- Any state to ST_HUNT: the decoder reset input is asserted.

Top module: `mdec_top`

## Requirements
- R1: After `rst_n` is released, `dec_sclk`, `dec_sdata`, `word_valid` and `cmd_sync` are all 0.
- R2: After an accepted sync, `cmd_sync` is 1 if the sync began with the high level (command word) and 0 if it began with the low level (data word). It keeps that value until the next sync is accepted.
- R3: A sync is accepted only when its first level lasts 17, 18 or 19 samples, at 12 samples per bit. A first level of 16 or fewer samples, or of 20 or more samples, produces no shift strobes and no valid flag.
- R4: The second level of the sync must be held for at least 17 samples. An earlier edge rejects the word.
- R5: An accepted word produces exactly 16 `dec_sclk` pulses, each one cycle long. `dec_sdata` carries one data bit with each pulse, most significant bit first. A bit is 1 when its first half is high and its second half is low, and 0 for the reverse.
- R6: The parity bit is the bit after the 16 data bits. The total number of ones in the 16 data bits plus the parity bit must be odd. If it is even, `word_valid` stays low.
- R7: For a clean word, `word_valid` is high for exactly 12 consecutive cycles, which is one bit time.
- R8: A bit whose two halves have the same level ends the word. The bits before it have already been strobed out. No further strobes follow, and `word_valid` stays low. This applies to the parity bit as well.
- R9: When `unipolar_sel` is 1, only `uni_in` is decoded and the pair inputs are ignored. When it is 0, the line is high for `bip_pos_in`=1, `bip_neg_in`=0 and low for the reverse. If both pair inputs are equal, the previous level is held, and `uni_in` is ignored.
- R10: `dec_reset` sends the decoder back to sync search in the next cycle. The word in progress produces no more strobes and no valid flag. The following word decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder sampling clock, 12 per bit time |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| dec_reset | input | 1 | Synchronous decoder reset back to sync search |
| unipolar_sel | input | 1 | 1: decode `uni_in`; 0: decode the complementary pair |
| bip_pos_in | input | 1 | Positive bus level of the complementary pair |
| bip_neg_in | input | 1 | Negative bus level of the complementary pair |
| uni_in | input | 1 | Single-ended line level |
| dec_sclk | output | 1 | One-cycle strobe per decoded data bit |
| dec_sdata | output | 1 | Decoded data bit, valid while `dec_sclk` is high |
| cmd_sync | output | 1 | Type of the last accepted sync: 1 command, 0 data |
| word_valid | output | 1 | One bit time high after a clean word with good parity |

## Verification
The assertions rely on three assumptions about the inputs:
- Line levels change only at whole-sample boundaries and hold steady within a sample.
- `unipolar_sel` stays constant while a word is in flight.
- `dec_reset` is applied as a single-cycle pulse.

The stimulus respects all three. Every input changes on the falling clock edge. The source is chosen once per word. The decoder reset is pulsed for one cycle, in the first half of a data bit, so that it cannot coincide with the bit decision of the preceding bit.

Each word is preceded by an idle stretch at the opposite level from the first sync half, so the sync always starts with a clean edge. Each word is followed by a long idle hold, so one word's outcome cannot carry into the next.

For words that should be rejected, the first data bit is chosen so that its leading edge breaks any run that could be mistaken for a sync.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    // Decoder controller states
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,   // searching for the mid-sync transition
        ST_SYNC2 = 2'd1,   // second sync level must persist
        ST_DATA  = 2'd2    // sampling data and parity bits
    } mdec_state_e;

endpackage

// File: rtl/mdec_line_front.sv
module mdec_line_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unipolar_sel,
    input  logic pos_in,
    input  logic neg_in,
    input  logic uni_in,
    output logic level,
    output logic level_prev,
    output logic chg
);

    localparam int LANES = 3;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             level_nxt;

    assign raw = {uni_in, neg_in, pos_in};

    // One synchronizer chain per raw input lane
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Source select; an ambiguous pair keeps the previous level
    always_comb begin
        level_nxt = level;
        if (unipolar_sel)                 level_nxt = synced[2];
        else if (synced[0] && !synced[1]) level_nxt = 1'b1;
        else if (!synced[0] && synced[1]) level_nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level      <= 1'b0;
            level_prev <= 1'b0;
        end else begin
            level      <= level_nxt;
            level_prev <= level;
        end
    end

    assign chg = (level != level_prev);

    assert_pair_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!unipolar_sel && (synced[0] == synced[1])) |=> $stable(level));

    assert_single_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unipolar_sel |=> (level == $past(synced[2])));

endmodule

// File: rtl/mdec_run_timer.sv
module mdec_run_timer #(
    parameter  int RUN_MAX = 20,
    localparam int W       = $clog2(RUN_MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         chg,
    output logic [W-1:0] run
);

    localparam logic [W-1:0] TOP = W'(RUN_MAX);

    // Length of the level that ends at an edge; saturates so stale runs never qualify
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run <= TOP;
        else if (clear)       run <= TOP;
        else if (chg)         run <= W'(1);
        else if (run != TOP)  run <= run + W'(1);
    end

    assert_run_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run != '0) && (run <= TOP));

endmodule

// File: rtl/mdec_valid_pulse.sv
module mdec_valid_pulse #(
    parameter  int LEN = 12,
    localparam int W   = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic valid
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (clear)     cnt <= '0;
        else if (start)     cnt <= W'(LEN);
        else if (cnt != '0) cnt <= cnt - W'(1);
    end

    assign valid = (cnt != '0);

    assert_start_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> valid);

endmodule

// File: rtl/mdec_top.sv
module mdec_top #(
    parameter int SPB         = 12,
    parameter int WORD_BITS   = 16,
    parameter int SYNC_TOL    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_reset,
    input  logic unipolar_sel,
    input  logic bip_pos_in,
    input  logic bip_neg_in,
    input  logic uni_in,
    output logic dec_sclk,
    output logic dec_sdata,
    output logic cmd_sync,
    output logic word_valid
);
    import mdec_pkg::*;

    localparam int HALF     = SPB / 2;
    localparam int SYNC_LEN = 3 * HALF;
    localparam int ACC_MIN  = SYNC_LEN - SYNC_TOL;
    localparam int ACC_MAX  = SYNC_LEN + SYNC_TOL;
    localparam int RUN_MAX  = ACC_MAX + 1;
    localparam int RUN_W    = $clog2(RUN_MAX + 1);
    localparam int PH_W     = $clog2(SYNC_LEN + 1);
    localparam int BPH_W    = $clog2(SPB);
    localparam int BIDX_W   = $clog2(WORD_BITS + 1);
    localparam int VLEN_W   = $clog2(SPB + 2);

    localparam logic [RUN_W-1:0]  RUN_LO   = RUN_W'(ACC_MIN);
    localparam logic [RUN_W-1:0]  RUN_HI   = RUN_W'(ACC_MAX);
    localparam logic [PH_W-1:0]   PH_MIN   = PH_W'(ACC_MIN);
    localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(SYNC_LEN - 1);
    localparam logic [BPH_W-1:0]  BPH_S1   = BPH_W'(SPB / 4);
    localparam logic [BPH_W-1:0]  BPH_S2   = BPH_W'(SPB / 4 + HALF);
    localparam logic [BPH_W-1:0]  BPH_END  = BPH_W'(SPB - 1);
    localparam logic [BIDX_W-1:0] BIDX_PAR = BIDX_W'(WORD_BITS);

    logic               lvl, lvl_prev, chg;
    logic [RUN_W-1:0]   run;
    mdec_state_e        state, nxt;
    logic [PH_W-1:0]    ph;
    logic [BPH_W-1:0]   bph;
    logic [BIDX_W-1:0]  bidx;
    logic               h1;
    logic               par_acc;
    logic               first_hi;
    logic               vstart;

    mdec_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .unipolar_sel (unipolar_sel),
        .pos_in       (bip_pos_in),
        .neg_in       (bip_neg_in),
        .uni_in       (uni_in),
        .level        (lvl),
        .level_prev   (lvl_prev),
        .chg          (chg)
    );

    mdec_run_timer #(.RUN_MAX(RUN_MAX)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (dec_reset),
        .chg   (chg),
        .run   (run)
    );

    mdec_valid_pulse #(.LEN(SPB)) u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (dec_reset),
        .start (vstart),
        .valid (word_valid)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: begin
                if (chg && (run >= RUN_LO) && (run <= RUN_HI)) nxt = ST_SYNC2;
            end
            ST_SYNC2: begin
                if (chg && (ph < PH_MIN))  nxt = ST_HUNT;
                else if (ph == PH_LAST)    nxt = ST_DATA;
            end
            ST_DATA: begin
                if ((bph == BPH_S2) && ((lvl == h1) || (bidx == BIDX_PAR))) nxt = ST_HUNT;
            end
            default: nxt = ST_HUNT;
        endcase
        if (dec_reset) nxt = ST_HUNT;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph        <= '0;
            bph       <= '0;
            bidx      <= '0;
            h1        <= 1'b0;
            par_acc   <= 1'b0;
            first_hi  <= 1'b0;
            cmd_sync  <= 1'b0;
            dec_sclk  <= 1'b0;
            dec_sdata <= 1'b0;
            vstart    <= 1'b0;
        end else begin
            dec_sclk <= 1'b0;
            vstart   <= 1'b0;
            unique case (state)
                ST_HUNT: begin
                    ph <= PH_W'(1);
                    if (nxt == ST_SYNC2) first_hi <= lvl_prev;
                end
                ST_SYNC2: begin
                    ph <= ph + PH_W'(1);
                    if (nxt == ST_DATA) begin
                        bph      <= '0;
                        bidx     <= '0;
                        par_acc  <= 1'b0;
                        cmd_sync <= first_hi;
                    end
                end
                ST_DATA: begin
                    bph <= (bph == BPH_END) ? '0 : bph + BPH_W'(1);
                    if (bph == BPH_S1) h1 <= lvl;
                    if ((bph == BPH_S2) && (lvl != h1)) begin
                        bidx <= bidx + BIDX_W'(1);
                        if (bidx != BIDX_PAR) begin
                            dec_sclk  <= !dec_reset;
                            dec_sdata <= h1;
                            par_acc   <= par_acc ^ h1;
                        end else begin
                            vstart <= (par_acc ^ h1) && !dec_reset;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Length of the current valid pulse, for checking only
    logic [VLEN_W-1:0] vlen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          vlen <= '0;
        else if (word_valid) vlen <= vlen + VLEN_W'(1);
        else                 vlen <= '0;
    end

    assert_sync_type_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(state) == ST_SYNC2) && (state == ST_DATA)) |-> $stable(cmd_sync));

    assert_early_edge_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SYNC2) && chg && (ph < PH_MIN)) |=> (state == ST_HUNT));

    assert_sclk_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_sclk |-> (state == ST_DATA));

    assert_bit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_sclk |-> (bidx <= BIDX_PAR));

    assert_valid_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(word_valid) && !$past(dec_reset)) |-> (vlen == VLEN_W'(SPB)));

    assert_valid_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vlen <= VLEN_W'(SPB));

    assert_manchester_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DATA) && (bph == BPH_S2) && (lvl == h1)) |=> ((state == ST_HUNT) && !dec_sclk));

    assert_decoder_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_reset |=> ((state == ST_HUNT) && !word_valid && !dec_sclk));

endmodule

// File: tb/test_mdec_top.sv
module test_mdec_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_reset = 1'b0;
    logic unipolar_sel = 1'b0;
    logic bip_pos_in = 1'b0;
    logic bip_neg_in = 1'b0;
    logic uni_in = 1'b0;
    logic dec_sclk, dec_sdata, cmd_sync, word_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          npulse = 0;
    int          vcyc = 0;
    logic [15:0] cap = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    mdec_top i_mdec_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_reset    (dec_reset),
        .unipolar_sel (unipolar_sel),
        .bip_pos_in   (bip_pos_in),
        .bip_neg_in   (bip_neg_in),
        .uni_in       (uni_in),
        .dec_sclk     (dec_sclk),
        .dec_sdata    (dec_sdata),
        .cmd_sync     (cmd_sync),
        .word_valid   (word_valid)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (dec_sclk) begin
                npulse = npulse + 1;
                cap    = {cap[14:0], dec_sdata};
            end
            if (word_valid) vcyc = vcyc + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one sample; hole makes the pair ambiguous (both low)
    task automatic put(input bit lv, input bit hole, input bit rpulse);
        @(negedge clk);
        dec_reset = rpulse;
        if (unipolar_sel) begin
            uni_in     = lv;
            bip_pos_in = ~lv;
            bip_neg_in = lv;
        end else begin
            uni_in = ~lv;
            if (hole) begin
                bip_pos_in = 1'b0;
                bip_neg_in = 1'b0;
            end else begin
                bip_pos_in = lv;
                bip_neg_in = ~lv;
            end
        end
    endtask

    task automatic run_word(input string req, input bit uni, input bit cmd,
                            input logic [15:0] data, input bit pgood,
                            input int len1, input int len2, input int errb,
                            input int rstb, input bit hole);
        bit   first_lv;
        bit   parbit;
        bit   b;
        bit   last;
        bit   acc;
        int   exp_p;
        int   exp_v;
        unipolar_sel = uni;
        npulse = 0;
        vcyc   = 0;
        cap    = '0;
        first_lv = cmd;
        parbit   = pgood ? ~(^data) : (^data);
        for (int i = 0; i < 30; i++) put(~first_lv, 1'b0, 1'b0);
        for (int i = 0; i < len1; i++) put(first_lv, hole && (i >= 5) && (i < 8), 1'b0);
        for (int i = 0; i < len2; i++) put(~first_lv, 1'b0, 1'b0);
        last = ~first_lv;
        for (int k = 0; k < 17; k++) begin
            b = (k < 16) ? data[15-k] : parbit;
            for (int i = 0; i < 6; i++) put(b, 1'b0, (k == rstb) && (i == 3));
            for (int i = 0; i < 6; i++) put((k == errb) ? b : ~b, 1'b0, 1'b0);
            last = (k == errb) ? b : ~b;
        end
        for (int i = 0; i < 40; i++) put(last, 1'b0, 1'b0);

        acc   = (len1 >= 17) && (len1 <= 19) && (len2 >= 17);
        exp_p = !acc ? 0 : (errb >= 0) ? errb : (rstb >= 0) ? rstb : 16;
        exp_v = (acc && errb < 0 && rstb < 0 && pgood) ? 12 : 0;
        check(npulse == exp_p, req, "shift strobes", npulse, exp_p);
        check(vcyc == exp_v, (exp_v != 0) ? "R7" : req, "valid cycles", vcyc, exp_v);
        if (exp_p == 16) check(cap == data, "R5", "shifted data", int'(cap), int'(data));
        if (acc) check(cmd_sync == cmd, "R2", "sync type", int'(cmd_sync), int'(cmd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: idle outputs after master reset
        check(dec_sclk == 1'b0, "R1", "dec_sclk", int'(dec_sclk), 0);
        check(dec_sdata == 1'b0, "R1", "dec_sdata", int'(dec_sdata), 0);
        check(word_valid == 1'b0, "R1", "word_valid", int'(word_valid), 0);
        check(cmd_sync == 1'b0, "R1", "cmd_sync", int'(cmd_sync), 0);

        // R3 / R2 / R9: first-level length sweep, both sources, both sync types
        for (int u = 0; u < 2; u++)
            for (int c = 0; c < 2; c++)
                for (int l1 = 15; l1 <= 21; l1++) begin
                    d = {c[0], 15'(l1 * 2731 + u * 977 + c * 31)};
                    run_word((u != 0) ? "R9" : "R3", u[0], c[0], d, 1'b1, l1, 18, -1, -1, 1'b0);
                end

        // R4: second-level length sweep
        for (int l2 = 14; l2 <= 19; l2++)
            run_word("R4", 1'b0, 1'b1, 16'hC35A ^ 16'(l2), 1'b1, 18, l2, -1, -1, 1'b0);
        for (int l2 = 15; l2 <= 18; l2++)
            run_word("R4", 1'b1, 1'b0, 16'h3C5A ^ 16'(l2 << 3), 1'b1, 18, l2, -1, -1, 1'b0);

        // R5: data patterns, MSB first
        run_word("R5", 1'b0, 1'b1, 16'h8000, 1'b1, 18, 18, -1, -1, 1'b0);
        run_word("R5", 1'b1, 1'b1, 16'hFFFF, 1'b1, 18, 18, -1, -1, 1'b0);
        run_word("R5", 1'b0, 1'b0, 16'h0001, 1'b1, 18, 18, -1, -1, 1'b0);
        run_word("R5", 1'b1, 1'b0, 16'h0000, 1'b1, 18, 18, -1, -1, 1'b0);
        run_word("R5", 1'b0, 1'b1, 16'hA5A5, 1'b1, 18, 18, -1, -1, 1'b0);

        // R6: even total parity suppresses valid
        run_word("R6", 1'b0, 1'b1, 16'hB00F, 1'b0, 18, 18, -1, -1, 1'b0);
        run_word("R6", 1'b1, 1'b0, 16'h7FFE, 1'b0, 18, 18, -1, -1, 1'b0);
        run_word("R6", 1'b0, 1'b0, 16'h0000, 1'b0, 18, 18, -1, -1, 1'b0);
        run_word("R6", 1'b1, 1'b1, 16'hFFFF, 1'b0, 18, 18, -1, -1, 1'b0);

        // R8: Manchester error at several bit positions, parity included
        run_word("R8", 1'b0, 1'b1, 16'h9249, 1'b1, 18, 18, 0, -1, 1'b0);
        run_word("R8", 1'b1, 1'b0, 16'h1248, 1'b1, 18, 18, 5, -1, 1'b0);
        run_word("R8", 1'b0, 1'b0, 16'h6DB6, 1'b1, 18, 18, 15, -1, 1'b0);
        run_word("R8", 1'b1, 1'b1, 16'hE1E1, 1'b1, 18, 18, 16, -1, 1'b0);

        // R9: ambiguous pair samples inside the first sync level hold the level
        run_word("R9", 1'b0, 1'b1, 16'hD00D, 1'b1, 18, 18, -1, -1, 1'b1);
        run_word("R9", 1'b0, 1'b0, 16'h2BAD, 1'b1, 17, 18, -1, -1, 1'b1);

        // R10: decoder reset mid word, then a normal word
        run_word("R10", 1'b0, 1'b1, 16'hF0F0, 1'b1, 18, 18, -1, 8, 1'b0);
        run_word("R10", 1'b1, 1'b0, 16'h0F0F, 1'b1, 18, 18, -1, 3, 1'b0);
        run_word("R10", 1'b0, 1'b1, 16'hCAFE, 1'b1, 18, 18, -1, -1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule